// File: doc/BRIEF.md
# Weighted Service Frame Multiplexer

This block builds the stream of outgoing link frames from a configurable number of independent service channels. Each channel delivers fixed-width words through a valid/ready port into a small buffer of its own. On every frame slot, which comes once every `FRAME_DIV` clock cycles, the block fills the frame's data field from one buffered channel. A credit-based weighted arbiter picks that channel, so each channel gets a share of the link set by a per-channel weight parameter. A word wider than the data field is cut into chunks. The chunks go out in consecutive frames, lowest chunk first, and the channel keeps the link until its last chunk has been sent.

An event vector bypasses the arbiter completely. It is sampled in the slot cycle and placed in every frame, whether the frame carries data or not. A change on an event input therefore reaches the link after a fixed number of cycles. When no channel holds data, an idle frame is emitted that still carries the events. Each frame also holds a channel identifier and a final-chunk flag, so that the receiver can put the words back together.

Top module: `svc_frame_mux`

## Requirements
- R1: Each channel i has its own buffer of `FIFO_DEPTH` words. `svc_ready[i]` is high while that buffer is not full, a word is taken on a clock edge where `svc_valid[i]` and `svc_ready[i]` are both high, and the words of one channel leave in the order they were taken.
- R2: `frame_vld` is high for exactly one cycle, and consecutive pulses are exactly `FRAME_DIV` cycles apart (2 by default).
- R3: Frame layout for the defaults (`FRM_W`=40): bits [31:0] chunk, bit 32 final-chunk flag, bits [34:33] channel identifier, bit 35 data flag (1 = data frame), bits [39:36] events.
- R4: The event field of each frame equals `evt_in` as sampled in the cycle before `frame_vld` is high. This holds whether the frame is idle or carries data, so an event change made just after one frame appears in the next frame.
- R5: A 64-bit word is carried in two consecutive data frames with the same identifier. The first frame carries bits [31:0] with the final flag 0, and the second carries bits [63:32] with the final flag 1.
- R6: Weights default to 3, 1 and 2 for channels 0, 1 and 2. A grant costs one credit per word. Only a requester with credit can win, and ties are searched round-robin starting after the last winner, with channel 0 searched first after reset. When every channel stays backlogged from reset, the first twelve words go to channels 0,1,2,0,2,0,1,2,0,2,0,0.
- R7: When no requester has credit left, all credits are reloaded to their weights in the same slot, so a lone backlogged channel is sent in back-to-back frames without idle frames, whatever its weight.
- R8: A slot with no buffered data produces an idle frame: the data flag, identifier, final flag and chunk are all 0.
- R9: While `rst_n` is low, `frame_vld` is 0 and every `svc_ready` bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| svc_valid | input | NUM_SVC | Per-channel word valid |
| svc_ready | output | NUM_SVC | Per-channel buffer has room |
| svc_data | input | NUM_SVC*WORD_W | Channel words, channel i at bits [i*WORD_W +: WORD_W] |
| evt_in | input | EVT_W | Event bits placed in every frame |
| frame_vld | output | 1 | One-cycle strobe per emitted frame |
| frame_data | output | FRM_W | Frame contents, layout per R3 |

## Verification
The assertions check on every cycle that frame pulses are spaced exactly `FRAME_DIV` apart, that each frame's event field matches `evt_in` of the previous cycle, that idle frames carry all-zero data fields, that identifiers stay in range, and that a non-final chunk is always followed by a data frame with the same identifier. Only the bench's scenarios can show the weighted grant order and its credit reload, the reassembly of split words in their accept order, the behaviour under backpressure, and the back-to-back sending of a lone channel. These depend on traffic history and on comparing full word sequences.

// File: rtl/svc_mux_pkg.sv
package svc_mux_pkg;

  typedef enum logic [0:0] {
    SEG_OPEN = 1'b0,
    SEG_HELD = 1'b1
  } seg_state_e;

  function automatic int unsigned div_up(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction

  function automatic int unsigned idx_width(input int unsigned count);
    return (count > 1) ? $clog2(count) : 1;
  endfunction

endpackage

// File: rtl/svc_fifo.sv
module svc_fifo #(
  parameter int unsigned WIDTH = 64,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  output logic             full,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty
);
  localparam int unsigned AW = svc_mux_pkg::idx_width(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_q, wr_nxt, rd_q, rd_nxt;
  logic [CW-1:0]    cnt_q, cnt_nxt;
  logic             do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_q];

  always_comb begin
    wr_nxt  = wr_q;
    rd_nxt  = rd_q;
    cnt_nxt = cnt_q;
    if (do_push) wr_nxt = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (do_pop)  rd_nxt = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    if (do_push && !do_pop)      cnt_nxt = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_nxt = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_nxt;
      rd_q  <= rd_nxt;
      cnt_q <= cnt_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= din;
  end

endmodule

// File: rtl/svc_wrr_arb.sv
module svc_wrr_arb #(
  parameter int unsigned             NUM_SVC = 3,
  parameter int unsigned             WGT_W   = 4,
  parameter logic [NUM_SVC*WGT_W-1:0] WEIGHTS = 12'h213,
  localparam int unsigned            SID_W   = svc_mux_pkg::idx_width(NUM_SVC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SVC-1:0] req,
  input  logic               advance,
  output logic               gnt_any,
  output logic [SID_W-1:0]   gnt_sid
);
  logic [WGT_W-1:0]   credit_q [NUM_SVC];
  logic [WGT_W-1:0]   credit_nxt [NUM_SVC];
  logic [SID_W-1:0]   last_q, last_nxt;
  logic [NUM_SVC-1:0] has_credit, eligible;
  logic               reload;

  always_comb begin
    for (int i = 0; i < NUM_SVC; i++) has_credit[i] = (credit_q[i] != '0);
    reload   = (|req) && !(|(req & has_credit));
    eligible = reload ? req : (req & has_credit);
  end

  always_comb begin
    int idx;
    gnt_any = 1'b0;
    gnt_sid = '0;
    for (int k = 1; k <= NUM_SVC; k++) begin
      idx = int'(last_q) + k;
      if (idx >= NUM_SVC) idx = idx - NUM_SVC;
      if (!gnt_any && eligible[idx]) begin
        gnt_any = 1'b1;
        gnt_sid = SID_W'(idx);
      end
    end
  end

  always_comb begin
    last_nxt = last_q;
    for (int i = 0; i < NUM_SVC; i++) begin
      credit_nxt[i] = credit_q[i];
      if (advance && gnt_any) begin
        credit_nxt[i] = reload ? WEIGHTS[i*WGT_W +: WGT_W] : credit_q[i];
        if (gnt_sid == SID_W'(i)) credit_nxt[i] = credit_nxt[i] - 1'b1;
      end
    end
    if (advance && gnt_any) last_nxt = gnt_sid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= SID_W'(NUM_SVC - 1);
      for (int i = 0; i < NUM_SVC; i++) credit_q[i] <= WEIGHTS[i*WGT_W +: WGT_W];
    end else begin
      last_q <= last_nxt;
      for (int i = 0; i < NUM_SVC; i++) credit_q[i] <= credit_nxt[i];
    end
  end

endmodule

// File: rtl/svc_frame_mux.sv
module svc_frame_mux #(
  parameter int unsigned              NUM_SVC    = 3,
  parameter int unsigned              WORD_W     = 64,
  parameter int unsigned              CHUNK_W    = 32,
  parameter int unsigned              EVT_W      = 4,
  parameter int unsigned              FIFO_DEPTH = 4,
  parameter int unsigned              FRAME_DIV  = 2,
  parameter int unsigned              WGT_W      = 4,
  parameter logic [NUM_SVC*WGT_W-1:0] WEIGHTS    = 12'h213,
  localparam int unsigned             SID_W      = svc_mux_pkg::idx_width(NUM_SVC),
  localparam int unsigned             FRM_W      = EVT_W + 1 + SID_W + 1 + CHUNK_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SVC-1:0]        svc_valid,
  output logic [NUM_SVC-1:0]        svc_ready,
  input  logic [NUM_SVC*WORD_W-1:0] svc_data,
  input  logic [EVT_W-1:0]          evt_in,
  output logic                      frame_vld,
  output logic [FRM_W-1:0]          frame_data
);
  import svc_mux_pkg::*;

  localparam int unsigned SEGS   = div_up(WORD_W, CHUNK_W);
  localparam int unsigned SEG_CW = idx_width(SEGS);
  localparam int unsigned PAD_W  = SEGS * CHUNK_W;
  localparam int unsigned CNT_W  = idx_width(FRAME_DIV);

  // per-channel buffers
  logic [NUM_SVC-1:0] buf_full, buf_empty, buf_pop;
  logic [WORD_W-1:0]  head_w [NUM_SVC];

  for (genvar g = 0; g < NUM_SVC; g++) begin : g_buf
    svc_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (svc_valid[g]),
      .din   (svc_data[g*WORD_W +: WORD_W]),
      .full  (buf_full[g]),
      .pop   (buf_pop[g]),
      .dout  (head_w[g]),
      .empty (buf_empty[g])
    );
  end
  assign svc_ready = ~buf_full;

  // frame slot timer
  logic [CNT_W-1:0] slot_q, slot_nxt;
  logic             tick;
  assign tick = (slot_q == CNT_W'(FRAME_DIV - 1));
  always_comb slot_nxt = tick ? '0 : slot_q + 1'b1;

  // arbiter
  logic             arb_any, arb_adv;
  logic [SID_W-1:0] arb_sid;
  seg_state_e       seg_q, seg_nxt;

  assign arb_adv = tick && (seg_q == SEG_OPEN);

  svc_wrr_arb #(.NUM_SVC(NUM_SVC), .WGT_W(WGT_W), .WEIGHTS(WEIGHTS)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (~buf_empty),
    .advance (arb_adv),
    .gnt_any (arb_any),
    .gnt_sid (arb_sid)
  );

  // segmenter
  logic [SID_W-1:0]  own_q, own_nxt, sel_sid;
  logic [SEG_CW-1:0] idx_q, idx_nxt, cur_seg;
  logic              have, is_last;
  logic [PAD_W-1:0]  padded;
  logic [CHUNK_W-1:0] chunk;
  logic [FRM_W-1:0]  frame_nxt;

  always_comb begin
    sel_sid = (seg_q == SEG_HELD) ? own_q : arb_sid;
    cur_seg = (seg_q == SEG_HELD) ? idx_q : '0;
    have    = (seg_q == SEG_HELD) || arb_any;
    is_last = (cur_seg == SEG_CW'(SEGS - 1));
    padded  = PAD_W'(head_w[sel_sid]);
    chunk   = padded[int'(cur_seg)*CHUNK_W +: CHUNK_W];
    for (int i = 0; i < NUM_SVC; i++)
      buf_pop[i] = tick && have && is_last && (sel_sid == SID_W'(i));
  end

  always_comb begin
    seg_nxt = seg_q;
    own_nxt = own_q;
    idx_nxt = idx_q;
    if (tick && have) begin
      if (is_last) begin
        seg_nxt = SEG_OPEN;
        idx_nxt = '0;
      end else begin
        seg_nxt = SEG_HELD;
        own_nxt = sel_sid;
        idx_nxt = cur_seg + 1'b1;
      end
    end
  end

  always_comb begin
    frame_nxt = {evt_in, have,
                 have ? sel_sid : {SID_W{1'b0}},
                 have && is_last,
                 have ? chunk : {CHUNK_W{1'b0}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q     <= '0;
      seg_q      <= SEG_OPEN;
      own_q      <= '0;
      idx_q      <= '0;
      frame_vld  <= 1'b0;
      frame_data <= '0;
    end else begin
      slot_q    <= slot_nxt;
      seg_q     <= seg_nxt;
      own_q     <= own_nxt;
      idx_q     <= idx_nxt;
      frame_vld <= tick;
      if (tick) frame_data <= frame_nxt;
    end
  end

endmodule

// File: rtl/svc_frame_mux_chk.sv
module svc_frame_mux_chk #(
  parameter int unsigned NUM_SVC   = 3,
  parameter int unsigned CHUNK_W   = 32,
  parameter int unsigned EVT_W     = 4,
  parameter int unsigned FRAME_DIV = 2,
  localparam int unsigned SID_W    = svc_mux_pkg::idx_width(NUM_SVC),
  localparam int unsigned FRM_W    = EVT_W + 1 + SID_W + 1 + CHUNK_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic [EVT_W-1:0] evt_in,
  input logic             frame_vld,
  input logic [FRM_W-1:0] frame_data
);
  localparam int unsigned LAST_B = CHUNK_W;
  localparam int unsigned SID_LO = CHUNK_W + 1;
  localparam int unsigned DAT_B  = CHUNK_W + 1 + SID_W;

  logic [7:0]       gap_q;
  logic             seen_q, open_q;
  logic [SID_W-1:0] open_sid_q;
  logic             f_dat, f_last;
  logic [SID_W-1:0] f_sid;

  assign f_dat  = frame_data[DAT_B];
  assign f_last = frame_data[LAST_B];
  assign f_sid  = frame_data[SID_LO +: SID_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q      <= '0;
      seen_q     <= 1'b0;
      open_q     <= 1'b0;
      open_sid_q <= '0;
    end else begin
      if (frame_vld) begin
        gap_q      <= 8'd1;
        seen_q     <= 1'b1;
        open_q     <= f_dat && !f_last;
        open_sid_q <= f_sid;
      end else if (gap_q != 8'hFF) begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  assert_frame_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_vld && seen_q) |-> (gap_q == 8'(FRAME_DIV)));

  assert_event_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_vld |-> (frame_data[FRM_W-1 -: EVT_W] == $past(evt_in)));

  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_vld && !f_dat) |-> (frame_data[DAT_B-1:0] == '0));

  assert_sid_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_vld && f_dat) |-> (int'(f_sid) < NUM_SVC));

  assert_chunk_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_vld && open_q) |-> (f_dat && (f_sid == open_sid_q)));

endmodule

bind svc_frame_mux svc_frame_mux_chk #(
  .NUM_SVC   (NUM_SVC),
  .CHUNK_W   (CHUNK_W),
  .EVT_W     (EVT_W),
  .FRAME_DIV (FRAME_DIV)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .evt_in     (evt_in),
  .frame_vld  (frame_vld),
  .frame_data (frame_data)
);

// File: tb/svc_frame_mux_test.sv
`timescale 1ns/1ps
module svc_frame_mux_test;
  localparam int N = 3;
  localparam int WW = 64;
  localparam int FW = 40;
  localparam int MAXF = 2048;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    s_valid = '0;
  logic [N-1:0]    s_ready;
  logic [N*WW-1:0] s_data = '0;
  logic [3:0]      evt = '0;
  logic            frame_vld;
  logic [FW-1:0]   frame_data;

  always #10 clk = ~clk;

  svc_frame_mux uut (
    .clk(clk), .rst_n(rst_n), .svc_valid(s_valid), .svc_ready(s_ready),
    .svc_data(s_data), .evt_in(evt), .frame_vld(frame_vld), .frame_data(frame_data)
  );

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  logic [FW-1:0] fr [MAXF];
  int fr_cyc [MAXF];
  int fcnt = 0;
  logic [N-1:0] rdy_low_seen = '0;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (rst_n && frame_vld && fcnt < MAXF) begin
      fr[fcnt] = frame_data;
      fr_cyc[fcnt] = cyc;
      fcnt = fcnt + 1;
    end
    if (rst_n) rdy_low_seen = rdy_low_seen | ~s_ready;
  end

  // frame fields per R3
  function automatic logic [3:0]  f_evt(input logic [FW-1:0] f); return f[39:36]; endfunction
  function automatic logic        f_dat(input logic [FW-1:0] f); return f[35]; endfunction
  function automatic logic [1:0]  f_sid(input logic [FW-1:0] f); return f[34:33]; endfunction
  function automatic logic        f_lst(input logic [FW-1:0] f); return f[32]; endfunction
  function automatic logic [31:0] f_chk(input logic [FW-1:0] f); return f[31:0]; endfunction

  function automatic logic [63:0] mk_word(input int s, input int k, input int tag);
    return {8'(tag), 8'(s), 16'(k), 8'(tag), 8'(s), 16'(k) ^ 16'hFFFF};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // reassembly
  logic [63:0] got_w [N][64];
  int got_n [N];
  int seq [256];
  int nseq, pair_err, first_dat, idle_between;

  task automatic parse(input int from);
    bit pend = 0;
    logic [31:0] lo = '0;
    logic [1:0] ps = '0;
    bit started = 0;
    nseq = 0; pair_err = 0; first_dat = -1; idle_between = 0;
    for (int s = 0; s < N; s++) got_n[s] = 0;
    for (int i = from; i < fcnt; i++) begin
      if (!f_dat(fr[i])) begin
        if (pend) pair_err++;
        pend = 0;
        if (started) idle_between++;
      end else begin
        if (!started) first_dat = i;
        started = 1;
        if (!pend) begin
          if (f_lst(fr[i])) pair_err++;
          else begin pend = 1; lo = f_chk(fr[i]); ps = f_sid(fr[i]); end
        end else begin
          if (!f_lst(fr[i]) || f_sid(fr[i]) != ps || int'(ps) >= N) pair_err++;
          else begin
            if (got_n[ps] < 64) got_w[ps][got_n[ps]] = {f_chk(fr[i]), lo};
            got_n[ps]++;
            if (nseq < 256) seq[nseq] = int'(ps);
            nseq++;
          end
          pend = 0;
        end
      end
    end
    if (pend) pair_err++;
  endtask

  task automatic produce(input int s, input int n, input int tag);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      s_valid[s] = 1'b1;
      s_data[s*WW +: WW] = mk_word(s, k, tag);
      while (!s_ready[s]) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    s_valid[s] = 1'b0;
  endtask

  task automatic check_words(input int s, input int n, input int tag, input string req);
    int bad = 0;
    if (got_n[s] != n) bad++;
    for (int k = 0; k < n && k < got_n[s]; k++)
      if (got_w[s][k] != mk_word(s, k, tag)) bad++;
    check(bad == 0, req, $sformatf("channel %0d words in order", s),
          64'(got_n[s]), 64'(n));
  endtask

  task automatic t_reset();
    check(frame_vld == 1'b0, "R9", "frame_vld in reset", 64'(frame_vld), 64'd0);
    check(s_ready == 3'b111, "R9", "svc_ready in reset", 64'(s_ready), 64'd7);
  endtask

  task automatic t_weighted();
    int start = fcnt;
    int exp_seq [12] = '{0,1,2,0,2,0,1,2,0,2,0,0};
    int bad = 0, evt_bad = 0, gap_bad = 0;
    evt = 4'h5;
    fork
      produce(0, 8, 1);
      produce(1, 8, 1);
      produce(2, 8, 1);
    join
    repeat (200) @(negedge clk);
    parse(start);
    for (int i = 0; i < 12; i++) if (i >= nseq || seq[i] != exp_seq[i]) bad++;
    check(bad == 0, "R6", "weighted grant order of first 12 words", 64'(bad), 64'd0);
    check_words(0, 8, 1, "R1");
    check_words(1, 8, 1, "R1");
    check_words(2, 8, 1, "R1");
    check(pair_err == 0, "R5", "chunk pairing", 64'(pair_err), 64'd0);
    for (int i = start; i < fcnt; i++) begin
      if (f_evt(fr[i]) != 4'h5) evt_bad++;
      if (i > start && fr_cyc[i] - fr_cyc[i-1] != 2) gap_bad++;
    end
    check(evt_bad == 0, "R4", "event field under traffic", 64'(evt_bad), 64'd0);
    check(gap_bad == 0, "R2", "frame spacing", 64'(gap_bad), 64'd0);
  endtask

  task automatic t_idle();
    @(negedge clk); evt = 4'hA;
    repeat (10) @(negedge clk);
    check(f_dat(fr[fcnt-1]) == 1'b0 && fr[fcnt-1][35:0] == '0, "R8", "idle frame fields",
          64'(fr[fcnt-1][35:0]), 64'd0);
    check(f_evt(fr[fcnt-1]) == 4'hA, "R4", "event in idle frame",
          64'(f_evt(fr[fcnt-1])), 64'hA);
  endtask

  task automatic t_evt_latency();
    @(negedge clk);
    while (!frame_vld) @(negedge clk);
    evt = 4'h3;
    @(negedge clk);
    while (!frame_vld) @(negedge clk);
    check(frame_data[39:36] == 4'h3, "R4", "event in very next frame",
          64'(frame_data[39:36]), 64'h3);
  endtask

  task automatic t_lone();
    int start = fcnt;
    int bad = 0;
    produce(1, 4, 2);
    repeat (40) @(negedge clk);
    parse(start);
    for (int i = 0; i < 8; i++)
      if (first_dat < 0 || !f_dat(fr[first_dat+i]) || f_sid(fr[first_dat+i]) != 2'd1) bad++;
    check(bad == 0, "R7", "lone channel back-to-back frames", 64'(bad), 64'd0);
    check_words(1, 4, 2, "R1");
  endtask

  task automatic t_backpressure();
    int start = fcnt;
    rdy_low_seen = '0;
    produce(2, 7, 3);
    repeat (60) @(negedge clk);
    parse(start);
    check(rdy_low_seen[2] == 1'b1, "R1", "ready drops when buffer full",
          64'(rdy_low_seen), 64'd4);
    check_words(2, 7, 3, "R1");
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_weighted();
    t_idle();
    t_evt_latency();
    t_lone();
    t_backpressure();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule